// File: doc/BRIEF.md
# Fast A20 Gate and Alternate Reset Port

This block is a one-byte system control register on the I/O bus, decoded at a single address (92h by default). It gives software two quick controls that do not need a round trip through the keyboard controller. The first is an address-line-20 enable. The second is a CPU reset request.

The A20 control bit is ORed with the keyboard controller's A20 gate. The result drives `a20_line`: when the line is low the CPU's address bit 20 is masked, and when it is high the bit passes through. A rising edge on the reset bit starts a counter-driven sequence: a hold-off delay, then a fixed-width active-low pulse. That pulse is ANDed with the keyboard controller's active-low reset to make the single CPU reset output. Both intervals are given in clock cycles. With the defaults of 14 and 6 at a 1 MHz count clock, they give the 14 µs wait and the 6 µs pulse. An enable input turns the whole port off, and a disabled port reads back as zeros.

Top module: `a20_rst_port`

## Requirements
- R1: After reset both control bits are 0. `a20_line` then follows `kbc_a20_gate`, `cpu_rst_n` follows `kbc_rst_n`, and a read returns 0.
- R2: A write at the port address while `port_en` is 1 stores `bus_wdata[1]` as the A20 bit. `a20_line` is 1 whenever that bit is 1, and equals `kbc_a20_gate` when it is 0.
- R3: A read at the port address while `port_en` is 1 returns, in the same cycle, the A20 bit in bit 1 and the reset bit in bit 0. Bits 7 to 2 read as 0.
- R4: While `port_en` is 0, writes change neither bit and reads return 0.
- R5: Accesses at any other address change nothing, and `bus_rdata` is 0 for them.
- R6: A write that takes bit 0 from 0 to 1 starts a sequence. `cpu_rst_n` goes low DELAY_CYC cycles after the write's clock edge and stays low for exactly PULSE_CYC cycles.
- R7: A write of 1 to bit 0 while it is already 1 starts nothing. A 0-to-1 change made while a sequence is in progress is ignored. The bit still stores the written value.
- R8: `cpu_rst_n` is low whenever `kbc_rst_n` is low or the alternate reset pulse is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the time base of the reset sequence |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_en | input | 1 | 1 enables the port; 0 blocks writes and zeros reads |
| bus_addr | input | ADDR_W | I/O address |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| kbc_a20_gate | input | 1 | A20 gate output of the keyboard controller |
| kbc_rst_n | input | 1 | Active-low reset output of the keyboard controller |
| a20_line | output | 1 | Combined A20 control; low masks address bit 20 |
| cpu_rst_n | output | 1 | Combined active-low CPU reset |

## Verification
The A20 path is tried with every pairing of the stored bit and the keyboard controller gate. Those writes are also repeated with the port disabled and at a wrong address. This separates an OR from a pass-through, and shows whether a blocked write leaked into the register. The reset path is tried with a clean 0-to-1 start, and the low cycles are counted one by one, so an off-by-one in either interval shows up. It is also tried with a repeated write of 1, and with 0-then-1 writes made during the delay and during the pulse. These tell edge-triggering apart from level-triggering, and show whether a busy sequence can be restarted. The keyboard reset is driven on its own to separate the AND merge from the pulse source.

// File: rtl/fgc_pkg.sv
package fgc_pkg;
  typedef enum logic [1:0] {
    PG_IDLE  = 2'd0,
    PG_DELAY = 2'd1,
    PG_PULSE = 2'd2
  } pg_state_e;

  // Bit positions inside the control byte; software decodes these.
  localparam int unsigned RST_BIT = 0;
  localparam int unsigned A20_BIT = 1;
endpackage

// File: rtl/fgc_rst_sync.sv
module fgc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/fgc_ctrl_reg.sv
module fgc_ctrl_reg
  import fgc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              a20_bit,
  output logic              pulse_start
);
  logic addr_hit, wr_ok, rd_ok;
  logic a20_q, a20_d, rst_q, rst_d, reg_en;
  logic [DATA_W-1:0] rd_vec;
  logic unused_wdata;

  assign addr_hit = (bus_addr == PORT_ADDR);
  assign wr_ok    = bus_wr & addr_hit & port_en;
  assign rd_ok    = bus_rd & addr_hit & port_en;
  assign reg_en   = wr_ok;
  assign unused_wdata = ^bus_wdata;

  // Next-state logic
  always_comb begin
    a20_d = a20_q;
    rst_d = rst_q;
    if (reg_en) begin
      a20_d = bus_wdata[A20_BIT];
      rst_d = bus_wdata[RST_BIT];
    end
  end

  // Register stage with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a20_q <= 1'b0;
      rst_q <= 1'b0;
    end else if (reg_en) begin
      a20_q <= a20_d;
      rst_q <= rst_d;
    end
  end

  // Start request only on a 0-to-1 change of the reset bit
  assign pulse_start = wr_ok & bus_wdata[RST_BIT] & ~rst_q;
  assign a20_bit     = a20_q;

  // Readback assembly: defined bits in place, all others zero
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_rd
    if (gi == A20_BIT) begin : g_a20
      assign rd_vec[gi] = a20_q;
    end else if (gi == RST_BIT) begin : g_rst
      assign rd_vec[gi] = rst_q;
    end else begin : g_zero
      assign rd_vec[gi] = 1'b0;
    end
  end

  assign bus_rdata = rd_ok ? rd_vec : '0;

  // R2
  write_a20_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (a20_q == $past(bus_wdata[A20_BIT])));
  // R4
  disabled_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !port_en) |=> ($stable(a20_q) && $stable(rst_q)));
  // R5
  other_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !addr_hit) |=> ($stable(a20_q) && $stable(rst_q)));
  // R7
  no_level_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |-> !pulse_start);
endmodule

// File: rtl/fgc_pulse_gen.sv
module fgc_pulse_gen
  import fgc_pkg::*;
#(
  parameter int unsigned DELAY_CYC = 14,
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic pulse_n
);
  localparam int unsigned MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
  localparam logic [CNT_W-1:0] DELAY_LD = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);

  pg_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      PG_IDLE: begin
        if (start) begin
          state_d = PG_DELAY;
          cnt_d   = DELAY_LD;
        end
      end
      PG_DELAY: begin
        if (cnt_zero) begin
          state_d = PG_PULSE;
          cnt_d   = PULSE_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PG_PULSE: begin
        if (cnt_zero) state_d = PG_IDLE;
        else          cnt_d   = cnt_q - 1'b1;
      end
      default: begin
        state_d = PG_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_n = (state_q != PG_PULSE);

  // R6
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_IDLE && start) |=> (state_q == PG_DELAY && cnt_q == DELAY_LD));
  // R6
  pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_PULSE && cnt_zero) |=> (state_q == PG_IDLE));
  // R6
  delay_to_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_DELAY && cnt_zero) |=> (state_q == PG_PULSE && cnt_q == PULSE_LD));
  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PG_PULSE && start) |=> (state_q != PG_DELAY));
endmodule

// File: rtl/fgc_out_merge.sv
module fgc_out_merge (
  input  logic a20_bit,
  input  logic kbc_a20_gate,
  input  logic pulse_n,
  input  logic kbc_rst_n,
  output logic a20_line,
  output logic cpu_rst_n
);
  assign a20_line  = a20_bit | kbc_a20_gate;
  assign cpu_rst_n = pulse_n & kbc_rst_n;
endmodule

// File: rtl/a20_rst_port.sv
module a20_rst_port #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92,
  parameter int unsigned DELAY_CYC = 14,
  parameter int unsigned PULSE_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              kbc_a20_gate,
  input  logic              kbc_rst_n,
  output logic              a20_line,
  output logic              cpu_rst_n
);
  logic rst_sync_n, a20_bit, pulse_start, pulse_n;

  fgc_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fgc_ctrl_reg #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PORT_ADDR (PORT_ADDR)
  ) u_ctrl_reg (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .port_en     (port_en),
    .bus_addr    (bus_addr),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .a20_bit     (a20_bit),
    .pulse_start (pulse_start)
  );

  fgc_pulse_gen #(
    .DELAY_CYC (DELAY_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) u_pulse_gen (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (pulse_start),
    .pulse_n (pulse_n)
  );

  fgc_out_merge u_out_merge (
    .a20_bit      (a20_bit),
    .kbc_a20_gate (kbc_a20_gate),
    .pulse_n      (pulse_n),
    .kbc_rst_n    (kbc_rst_n),
    .a20_line     (a20_line),
    .cpu_rst_n    (cpu_rst_n)
  );

  // R8
  pulse_merge_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pulse_n |-> !cpu_rst_n);
  // R4
  disabled_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !port_en |-> (bus_rdata == '0));
  // R2
  a20_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    a20_bit |-> a20_line);
endmodule

// File: tb/a20_rst_port_bench.sv
module a20_rst_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int D = 14;
  localparam int P = 6;
  localparam logic [15:0] PADDR = 16'h0092;

  logic clk = 1'b0;
  logic rst_n, port_en, bus_wr, bus_rd, kbc_a20_gate, kbc_rst_n;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic a20_line, cpu_rst_n;

  int checks = 0;
  int errors = 0;
  int low_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  a20_rst_port #(
    .ADDR_W(16), .DATA_W(8), .PORT_ADDR(PADDR), .DELAY_CYC(D), .PULSE_CYC(P)
  ) u_a20_rst_port (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .kbc_a20_gate(kbc_a20_gate),
    .kbc_rst_n(kbc_rst_n), .a20_line(a20_line), .cpu_rst_n(cpu_rst_n)
  );

  always @(negedge clk) if (!cpu_rst_n) low_cnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge after the write edge.
  task automatic wr(input logic [15:0] a, input logic [7:0] d, input logic en);
    bus_addr = a; bus_wdata = d; port_en = en; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; port_en = 1'b1;
  endtask

  task automatic rd(input logic [15:0] a, input logic en, output logic [7:0] d);
    bus_addr = a; port_en = en; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0; port_en = 1'b1;
  endtask

  // {en, hit, gate, wd[1:0], exp_a20, exp_rd[1:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b1_1_0_10_1_10,
    8'b1_1_1_00_1_00,
    8'b1_1_0_00_0_00,
    8'b0_1_0_10_0_00,
    8'b1_0_0_10_0_00,
    8'b1_1_1_10_1_10,
    8'b0_1_0_00_1_10,
    8'b1_0_0_00_1_10
  };

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    rst_n = 1'b0; port_en = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_addr = '0; bus_wdata = '0; kbc_a20_gate = 1'b0; kbc_rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 a20_line", a20_line, 0);
    chk("R1 cpu_rst_n", cpu_rst_n, 1);
    rd(PADDR, 1'b1, r); chk("R1 read", r, 8'h00);
    kbc_a20_gate = 1'b1; #1 chk("R1 a20 follows gate", a20_line, 1);
    kbc_a20_gate = 1'b0;
    @(negedge clk);

    // Table walk: R2, R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      kbc_a20_gate = VEC[i][5];
      wr(VEC[i][6] ? PADDR : 16'h0060, {6'b0, VEC[i][4:3]}, VEC[i][7]);
      chk($sformatf("R2/R4/R5 vec%0d a20_line", i), a20_line, VEC[i][2]);
      rd(PADDR, 1'b1, r);
      chk($sformatf("R3 vec%0d read", i), r, {6'b0, VEC[i][1:0]});
      @(negedge clk);
    end
    kbc_a20_gate = 1'b0;

    // R3 upper bits zero
    wr(PADDR, 8'hFE, 1'b1);
    rd(PADDR, 1'b1, r); chk("R3 upper bits zero", r, 8'h02);
    // R4 disabled read
    rd(PADDR, 1'b0, r); chk("R4 disabled read", r, 8'h00);
    // R5 other-address read
    rd(16'h0093, 1'b1, r); chk("R5 other address read", r, 8'h00);
    @(negedge clk);

    // R6 pulse timing
    wr(PADDR, 8'h00, 1'b1);
    low_cnt = 0;
    wr(PADDR, 8'h01, 1'b1);
    for (int j = 0; j <= D + P + 1; j++) begin
      checks++;
      if (cpu_rst_n !== !(j >= D && j < D + P)) begin
        errors++;
        $display("FAIL R6 cycle %0d: actual %0b expected %0b", j, cpu_rst_n, !(j >= D && j < D + P));
      end
      @(negedge clk);
    end
    chk("R6 low cycle count", low_cnt, P);

    // R7 level write does not start
    low_cnt = 0;
    wr(PADDR, 8'h01, 1'b1);
    repeat (D + P + 4) @(negedge clk);
    chk("R7 repeated 1 no pulse", low_cnt, 0);

    // R7 re-edge during delay ignored
    low_cnt = 0;
    wr(PADDR, 8'h00, 1'b1);
    wr(PADDR, 8'h01, 1'b1);
    repeat (3) @(negedge clk);
    wr(PADDR, 8'h00, 1'b1);
    wr(PADDR, 8'h01, 1'b1);
    repeat (2 * (D + P)) @(negedge clk);
    chk("R7 edge during delay ignored", low_cnt, P);
    rd(PADDR, 1'b1, r); chk("R7 bit still stored", r[0], 1);
    @(negedge clk);

    // R7 re-edge during pulse ignored
    low_cnt = 0;
    wr(PADDR, 8'h00, 1'b1);
    wr(PADDR, 8'h01, 1'b1);
    repeat (D) @(negedge clk);
    wr(PADDR, 8'h00, 1'b1);
    wr(PADDR, 8'h01, 1'b1);
    repeat (2 * (D + P)) @(negedge clk);
    chk("R7 edge during pulse ignored", low_cnt, P);

    // R8 keyboard reset merge
    kbc_rst_n = 1'b0; #1 chk("R8 kbc reset low", cpu_rst_n, 0);
    kbc_rst_n = 1'b1; #1 chk("R8 kbc reset released", cpu_rst_n, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule